// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller

This block is a synchronous model of the write path of a byte-wide nonvolatile memory that programs a whole page at a time. The host drives active-low chip-select, write-strobe and read-strobe pins together with an address and a data byte. The block samples them on every clock. Bytes written within one page go into a page register, and a per-byte valid bit marks each byte that was loaded. When the host stops writing for long enough, the block starts a programming period with its own timer. At the end of that period it copies only the marked bytes into the storage array.

While programming is in progress, a read does not return array contents. It returns two status bits instead. The top bit is the complement of bit 7 of the last accepted byte. The next bit flips after every completed read. A host can poll either bit to find out when the array is ready again. A write to a page other than the one being loaded is dropped and reported on an error pin. Any write made while programming is busy is dropped without a report.

Top module: `eeprom_page_wr`

## Requirements
- R1: After reset, `dout_en` and `err` are 0, `dout` is 0, and every array byte reads as 0x00.
- R2: Suppose `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled at a clock edge. Then from that edge `dout_en`=1 and `dout` carries the read value. In every other input case both outputs are 0 from that edge.
- R3: A write is active while `ce_n` and `we_n` are both 0. The address is captured in the first cycle in which the write is active, so later address changes within the same strobe have no effect. The data byte is captured from `din` in the first cycle in which either strobe is back high.
- R4: Address bits [5:0] select the byte within a 64-byte page. Bits [14:6] select the page. The array holds 2^ARR_AW bytes and stores each byte at the address modulo that size.
- R5: Each accepted byte restarts the load window. Programming begins LOAD_WIN clock edges after the edge that captured the last accepted byte.
- R6: When programming ends, only the bytes loaded during the window are written to the array. A byte loaded twice keeps its later value. Every other location keeps its old contents.
- R7: A write whose page bits differ from the page being loaded is dropped and does not restart the window. `err` is 1 for exactly the one cycle that follows its data capture.
- R8: A write that completes while programming is busy changes nothing and does not raise `err`.
- R9: A read sampled while programming is busy returns, on bit 7, the complement of bit 7 of the last accepted byte. Bits 5..0 of that read are 0.
- R10: On bit 6, the first busy read returns 0, and each completed read (read strobe released) inverts the value returned by the next read.
- R11: Programming lasts PROG_CYC cycles. After that, reads return the array contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 15 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status, 0 when not driven |
| dout_en | output | 1 | High when the data bus is driven |
| err | output | 1 | One-cycle pulse for a dropped off-page write |

## Verification
The state that can silently go wrong is hidden: the page tag, the valid bits, the window counter and the latched address. If a valid bit is set by mistake, or left over from an earlier load, it shows up only after the next programming period, as a changed byte that was never written. If the window counter is off, the busy status bits appear a cycle early or late on a read that is held across the expiry. If the toggle or the poll bit is stale, the next busy read shows it. For this reason the bench runs a behavioural model alongside the design and compares every output on every clock, and it holds reads across each expected change.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wst_e;
endpackage

// File: rtl/ewc_pagebuf.sv
module ewc_pagebuf #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 6,
    localparam int PAGE_BYTES = 1 << OFF_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [OFF_W-1:0]                      wr_off,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  clr,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]     bytes_o,
    output logic [PAGE_BYTES-1:0]                 valid_o
);
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]             valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = clr ? '0 : valid_q;
        if (wr_en) begin
            data_d[wr_off]  = wr_data;
            valid_d[wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign bytes_o = data_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/ewc_array.sv
module ewc_array #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 6,
    parameter int ARR_AW = 9,
    localparam int PAGE_BYTES = 1 << OFF_W,
    localparam int DEPTH      = 1 << ARR_AW,
    localparam int PG_W       = ARR_AW - OFF_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [PG_W-1:0]                   page_i,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes_i,
    input  logic [PAGE_BYTES-1:0]             valid_i,
    input  logic [ARR_AW-1:0]                 raddr,
    output logic [DATA_W-1:0]                 rdata
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [ARR_AW-1:0]            loc;

    always_comb begin
        mem_d = mem_q;
        loc   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            loc = ARR_AW'(i);
            if (commit && loc[ARR_AW-1:OFF_W] == page_i && valid_i[loc[OFF_W-1:0]])
                mem_d[i] = bytes_i[loc[OFF_W-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_page_wr.sv
module eeprom_page_wr
    import ewc_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 6,
    parameter int ARR_AW   = 9,
    parameter int LOAD_WIN = 256,
    parameter int PROG_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              err
);
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int ARR_PG_W   = ARR_AW - OFF_W;
    localparam int CNT_MAX    = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        wst_e              st;
        logic [CNT_W-1:0]  cnt;
        logic              w;
        logic              rd;
        logic [ADDR_W-1:0] alat;
        logic [PAGE_W-1:0] page;
        logic              poll;
        logic              tog;
        logic              err;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } regs_t;

    regs_t q, d;

    logic                              w_now, rd_now, w_rise, w_fall;
    logic                              buf_wr, buf_clr, pg_commit;
    logic [PAGE_W-1:0]                 cap_page;
    logic [OFF_W-1:0]                  cap_off;
    logic [DATA_W-1:0]                 status, rdata;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
    logic [PAGE_BYTES-1:0]             buf_valid;

    assign w_now    = !ce_n && !we_n;
    assign rd_now   = !ce_n && !oe_n && we_n;
    assign w_rise   = w_now && !q.w;
    assign w_fall   = !w_now && q.w;
    assign cap_page = q.alat[ADDR_W-1:OFF_W];
    assign cap_off  = q.alat[OFF_W-1:0];

    always_comb begin
        status           = '0;
        status[DATA_W-1] = ~q.poll;
        status[DATA_W-2] = q.tog;
    end

    always_comb begin
        d         = q;
        d.w       = w_now;
        d.rd      = rd_now;
        d.err     = 1'b0;
        buf_wr    = 1'b0;
        buf_clr   = 1'b0;
        pg_commit = 1'b0;
        if (w_rise) d.alat = addr;
        if (q.st == ST_PROG && q.rd && !rd_now) d.tog = ~q.tog;
        unique case (q.st)
            ST_IDLE: begin
                if (w_fall) begin
                    buf_wr = 1'b1;
                    d.page = cap_page;
                    d.st   = ST_LOAD;
                    d.cnt  = '0;
                end
            end
            ST_LOAD: begin
                if (w_fall && cap_page == q.page) begin
                    buf_wr = 1'b1;
                    d.cnt  = '0;
                end else begin
                    if (w_fall) d.err = 1'b1;
                    if (q.cnt == CNT_W'(LOAD_WIN - 1)) begin
                        d.st  = ST_PROG;
                        d.cnt = '0;
                        d.tog = 1'b0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_PROG: begin
                if (q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    pg_commit = 1'b1;
                    buf_clr   = 1'b1;
                    d.st      = ST_IDLE;
                    d.cnt     = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (buf_wr) d.poll = din[DATA_W-1];
        d.oe   = rd_now;
        d.dout = !rd_now ? '0 : ((q.st == ST_PROG) ? status : rdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    ewc_pagebuf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_wr),
        .wr_off (cap_off),
        .wr_data(din),
        .clr    (buf_clr),
        .bytes_o(buf_bytes),
        .valid_o(buf_valid)
    );

    ewc_array #(.DATA_W(DATA_W), .OFF_W(OFF_W), .ARR_AW(ARR_AW)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (pg_commit),
        .page_i (q.page[ARR_PG_W-1:0]),
        .bytes_i(buf_bytes),
        .valid_i(buf_valid),
        .raddr  (addr[ARR_AW-1:0]),
        .rdata  (rdata)
    );

    assign dout    = q.dout;
    assign dout_en = q.oe;
    assign err     = q.err;
endmodule

// File: rtl/eeprom_page_wr_chk.sv
module eeprom_page_wr_chk
    import ewc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_n,
    input logic                  we_n,
    input logic                  oe_n,
    input logic                  dout_en,
    input logic [DATA_W-1:0]     dout,
    input logic                  err,
    input wst_e                  st,
    input logic [PAGE_BYTES-1:0] valid,
    input logic                  poll,
    input logic                  tog
);
    assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |=> (!dout_en && dout == '0));

    assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en);

    assert_err_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(st) == ST_LOAD);

    assert_valid_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_PROG) |-> valid == '0);

    assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && $past(st) == ST_PROG) |-> $stable(valid));

    assert_poll_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(st) == ST_PROG) |-> dout[DATA_W-1] == !$past(poll));

    assert_toggle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && $past(st) == ST_LOAD) |-> !tog);
endmodule

bind eeprom_page_wr eeprom_page_wr_chk #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .dout_en(dout_en),
    .dout   (dout),
    .err    (err),
    .st     (q.st),
    .valid  (buf_valid),
    .poll   (q.poll),
    .tog    (q.tog)
);

// File: tb/eeprom_page_wr_tb.sv
module eeprom_page_wr_tb;
    localparam int LW = 12;
    localparam int PC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, err;

    int checks = 0, fails = 0, cycles = 0;

    always #2 clk = ~clk;

    eeprom_page_wr #(.LOAD_WIN(LW), .PROG_CYC(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 loading, 2 programming
    logic [7:0] m_mem [512];
    logic [7:0] m_buf [int];
    int   m_st, m_cnt, m_alat, m_page;
    bit   m_w, m_r, m_tog, m_b7;
    bit   e_en, e_err, e_busy;
    logic [7:0] e_dout;

    always @(posedge clk) begin
        bit w, r, fall;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'h00;
            m_buf.delete();
            m_st = 0; m_cnt = 0; m_alat = 0; m_page = 0;
            m_w = 0; m_r = 0; m_tog = 0; m_b7 = 0;
            e_en = 0; e_err = 0; e_busy = 0; e_dout = 0;
        end else begin
            w = !ce_n && !we_n;
            r = !ce_n && !oe_n && we_n;
            fall = !w && m_w;
            e_en = r;
            e_busy = r && (m_st == 2);
            e_dout = !r ? 8'h00 : (m_st == 2 ? {~m_b7, m_tog, 6'b0} : m_mem[int'(addr) % 512]);
            e_err = 0;
            if (m_st == 2 && m_r && !r) m_tog = ~m_tog;
            if (m_st == 0) begin
                if (fall) begin
                    m_page = m_alat / 64; m_buf.delete();
                    m_buf[m_alat % 64] = din; m_b7 = din[7]; m_st = 1; m_cnt = 0;
                end
            end else if (m_st == 1) begin
                if (fall && (m_alat / 64) == m_page) begin
                    m_buf[m_alat % 64] = din; m_b7 = din[7]; m_cnt = 0;
                end else begin
                    if (fall) e_err = 1;
                    if (m_cnt == LW - 1) begin m_st = 2; m_cnt = 0; m_tog = 0; end
                    else m_cnt++;
                end
            end else begin
                if (m_cnt == PC - 1) begin
                    foreach (m_buf[k]) m_mem[(m_page * 64 + k) % 512] = m_buf[k];
                    m_buf.delete(); m_st = 0; m_cnt = 0;
                end else m_cnt++;
            end
            if (w && !m_w) m_alat = int'(addr);
            m_w = w; m_r = r;
        end
    end

    always @(negedge clk) begin
        if (rst_n)
            chk(e_err ? "R7 model" : (e_busy ? "R9 R10 model" : "R2 R6 model"),
                {22'd0, err, dout_en, dout}, {22'd0, e_err, e_en, e_dout});
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        addr = a; ce_n = 1'b0; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = ~a; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; din = 8'h00;
    endtask

    task automatic wr_ce_last(input logic [14:0] a, input logic [7:0] d);
        addr = a; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); addr = ~a; din = d;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1; din = 8'h00;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] v);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int first;
        repeat (3) @(negedge clk);
        chk("R1 dout_en in reset", {31'd0, dout_en}, 32'd0);
        chk("R1 err in reset", {31'd0, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(15'h005, v); chk("R1 array cleared", {24'd0, v}, 32'h00);

        wr(15'h043, 8'hA5);
        wr(15'h040, 8'h11);
        wr_ce_last(15'h043, 8'h5C);
        repeat (LW) @(negedge clk);
        rd(15'h043, v);
        chk("R9 poll bit", {31'd0, v[7]}, 32'd1);
        chk("R10 first toggle", {31'd0, v[6]}, 32'd0);
        chk("R9 low bits zero", {26'd0, v[5:0]}, 32'd0);
        rd(15'h043, v);
        chk("R10 second toggle", {31'd0, v[6]}, 32'd1);
        wr(15'h045, 8'h77);
        chk("R8 no err while busy", {31'd0, err}, 32'd0);
        repeat (PC) @(negedge clk);
        rd(15'h043, v); chk("R6 R4 overwrite keeps last", {24'd0, v}, 32'h5C);
        rd(15'h040, v); chk("R11 true data", {24'd0, v}, 32'h11);
        rd(15'h045, v); chk("R8 busy write dropped", {24'd0, v}, 32'h00);
        rd(15'h041, v); chk("R6 unloaded byte", {24'd0, v}, 32'h00);
        rd(15'h1BC, v); chk("R3 late address ignored", {24'd0, v}, 32'h00);

        wr(15'h041, 8'hEE);
        repeat (LW + PC + 4) @(negedge clk);
        rd(15'h043, v); chk("R6 other bytes untouched", {24'd0, v}, 32'h5C);
        rd(15'h041, v); chk("R6 single byte page", {24'd0, v}, 32'hEE);

        wr(15'h080, 8'h80);
        wr(15'h0C0, 8'h33);
        chk("R7 err pulse", {31'd0, err}, 32'd1);
        @(negedge clk);
        chk("R7 err one cycle", {31'd0, err}, 32'd0);
        repeat (LW) @(negedge clk);
        rd(15'h080, v); chk("R9 poll of 0x80", {31'd0, v[7]}, 32'd0);
        repeat (PC + 4) @(negedge clk);
        rd(15'h0C0, v); chk("R7 off-page byte dropped", {24'd0, v}, 32'h00);
        rd(15'h080, v); chk("R11 page written", {24'd0, v}, 32'h80);

        wr(15'h0C1, 8'h01);
        for (int i = 0; i < 3; i++) begin
            repeat (LW - 5) @(negedge clk);
            wr(15'h0C2 + 15'(i), 8'h10 + 8'(i));
        end
        repeat (LW + PC + 4) @(negedge clk);
        rd(15'h0C4, v); chk("R5 window restarted", {24'd0, v}, 32'h12);

        wr(15'h100, 8'h22);
        first = 0;
        addr = 15'h101; ce_n = 1'b0; oe_n = 1'b0;
        for (int k = 1; k <= LW + 4; k++) begin
            @(negedge clk);
            if (dout[7] && first == 0) first = k;
        end
        ce_n = 1'b1; oe_n = 1'b1;
        chk("R5 busy starts after window", first, LW + 1);
        repeat (PC + 4) @(negedge clk);
        rd(15'h100, v); chk("R11 data after program", {24'd0, v}, 32'h22);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule